// File: doc/BRIEF.md
# Channel Status and Service-Request Aggregator

This block keeps the condition status of a multi-channel sensing or actuating device and turns it into a single service-request line for the host. Every channel has a 16-bit standard status word and a 16-bit auxiliary status word. A global entry has its own standard word, and its auxiliary word is formed from the channels. Each of these entries has a standard and an auxiliary interrupt mask. Channel logic reports conditions through set and clear strobes. A bit stays high from its set strobe until its clear strobe, so it follows the condition it reports.

The host reads status words and reads or writes masks through a flat register port. Entry 0 is the global entry and entries 1 to NUM_CH are the channels. A service-request bit in bit 0 of each standard word is derived from the masked status bits, and no mask can suppress it. A registered active-low interrupt line goes low while any entry requests service. Two device reset commands are available: one for the whole device and one for each channel. Both clear status and leave the masks alone. Only the power-on reset restores the mask defaults.

Top module: `sts_irq_aggregator`

## Requirements
- R1: Set strobes store standard bits 1 (trigger acknowledge), 2 (has been reset) and 8 (operational) for a channel, and additionally bit 3 (invalid command) for the global entry. Strobe vector bit positions equal register bit positions, the bit reads 1 from the cycle after the strobe, and a set wins over a clear of the same bit in the same cycle.
- R2: A clear strobe on a stored bit makes it read 0 from the next cycle, which models the condition going away.
- R3: Standard bits 9 to 15 and auxiliary bits 5 to 15 always read 0. Strobes to standard bits 0, 4 and 9 to 15, to channel standard bit 3, and to auxiliary bits 5 to 15 have no effect.
- R4: Auxiliary bits 0 to 4 (busy, failed calibration, failed self-test, consumables exhausted, out of range) are stored per channel. A channel's standard bit 4 reads 1 exactly when any of its auxiliary bits 0 to 4 is 1.
- R5: Global auxiliary bit n reads as the OR of auxiliary bit n over all channels. Global standard bit 4 reads as the OR of every channel's standard bit 4.
- R6: After power-on reset every standard mask reads 0xFFFF and every auxiliary mask reads 0x0000. Host writes replace a mask, and neither reset command changes any mask.
- R7: Standard bit 0 of an entry reads 1 exactly when some standard bit 1 to 15 is 1 together with its standard mask bit, or some auxiliary bit is 1 together with its auxiliary mask bit. Standard mask bit 0 has no effect.
- R8: irq_no is low exactly when, one cycle earlier, bit 0 of the global entry or of any channel entry was 1. It is high during and just after reset.
- R9: host_addr_i 0 selects the global entry and k+1 selects channel k. host_sel_i selects 0 standard status, 1 auxiliary status, 2 standard mask, 3 auxiliary mask. Other addresses read 0 and writes to them change no mask.
- R10: soft_rst_i clears all stored status bits of every entry in the next cycle. ch_rst_i[k] clears only channel k. A reset wins over a set strobe in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Power-on reset, active low, asynchronous |
| soft_rst_i | input | 1 | Device reset command: clears all status |
| ch_rst_i | input | NUM_CH | Per-channel reset command: clears that channel's status |
| glb_std_set_i | input | 16 | Global standard condition set strobes |
| glb_std_clr_i | input | 16 | Global standard condition clear strobes |
| ch_std_set_i | input | NUM_CH*16 | Channel standard set strobes, channel k at bits k*16 and up |
| ch_std_clr_i | input | NUM_CH*16 | Channel standard clear strobes |
| ch_aux_set_i | input | NUM_CH*16 | Channel auxiliary set strobes |
| ch_aux_clr_i | input | NUM_CH*16 | Channel auxiliary clear strobes |
| host_addr_i | input | ADDR_W | Entry select, 0 is global |
| host_sel_i | input | 2 | Register select within the entry |
| host_wr_i | input | 1 | Mask write strobe |
| host_wdata_i | input | 16 | Mask write data |
| host_rdata_o | output | 16 | Read data, combinational from address and select |
| irq_no | output | 1 | Service-request line, active low, registered |

## Verification
The assertions assume that the set strobes arrive as single-cycle pulses on clock edges. They also assume that a reset command presented with a set strobe is meant to win, so the capture check is qualified by the absence of both resets. The mask-stability check relies on host_wr_i being the only way to change a mask, so the bench drives writes only through that strobe. The bench changes inputs on the falling edge and holds them for a whole cycle, which keeps every strobe a clean one-cycle pulse.

// File: rtl/sts_pkg.sv
package sts_pkg;
   localparam int REG_W = 16;

   localparam int SB_SRQ   = 0;
   localparam int SB_AUXAV = 4;

   localparam logic [REG_W-1:0] CH_STD_STORE  = 16'h0106;
   localparam logic [REG_W-1:0] GLB_STD_STORE = 16'h010E;
   localparam logic [REG_W-1:0] AUX_STORE     = 16'h001F;
   localparam logic [REG_W-1:0] AUXAV_BIT     = 16'h0001 << SB_AUXAV;

   localparam logic [REG_W-1:0] STD_MASK_DEF  = 16'hFFFF;
   localparam logic [REG_W-1:0] AUX_MASK_DEF  = 16'h0000;

   typedef enum logic [1:0] {
      SEL_STD  = 2'd0,
      SEL_AUX  = 2'd1,
      SEL_SMSK = 2'd2,
      SEL_AMSK = 2'd3
   } host_sel_e;
endpackage

// File: rtl/sts_entry_regs.sv
module sts_entry_regs
   import sts_pkg::*;
#(
   parameter logic [REG_W-1:0] STORE = 16'h0000
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wipe_i,
   input  logic [REG_W-1:0] set_i,
   input  logic [REG_W-1:0] clr_i,
   output logic [REG_W-1:0] q_o
);
   logic [REG_W-1:0] q_r;
   logic [REG_W-1:0] q_nxt;

   always_comb begin
      if (wipe_i) q_nxt = '0;
      else        q_nxt = ((q_r & ~clr_i) | set_i) & STORE;
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) q_r <= '0;
      else         q_r <= q_nxt;
   end

   assign q_o = q_r;
endmodule

// File: rtl/sts_mask_pair.sv
module sts_mask_pair
   import sts_pkg::*;
#(
   parameter logic [REG_W-1:0] STD_DEF = STD_MASK_DEF,
   parameter logic [REG_W-1:0] AUX_DEF = AUX_MASK_DEF
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             wr_std_i,
   input  logic             wr_aux_i,
   input  logic [REG_W-1:0] wdata_i,
   output logic [REG_W-1:0] std_o,
   output logic [REG_W-1:0] aux_o
);
   logic [REG_W-1:0] std_r;
   logic [REG_W-1:0] aux_r;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         std_r <= STD_DEF;
         aux_r <= AUX_DEF;
      end else begin
         if (wr_std_i) std_r <= wdata_i;
         if (wr_aux_i) aux_r <= wdata_i;
      end
   end

   assign std_o = std_r;
   assign aux_o = aux_r;
endmodule

// File: rtl/sts_srq_calc.sv
module sts_srq_calc
   import sts_pkg::*;
(
   input  logic [REG_W-1:0] std_i,
   input  logic [REG_W-1:0] aux_i,
   input  logic [REG_W-1:0] smask_i,
   input  logic [REG_W-1:0] amask_i,
   output logic             srq_o,
   output logic [REG_W-1:0] view_o
);
   logic std_hit;
   logic aux_hit;

   assign std_hit = |(std_i[REG_W-1:1] & smask_i[REG_W-1:1]);
   assign aux_hit = |(aux_i & amask_i);
   assign srq_o   = std_hit | aux_hit;
   assign view_o  = {std_i[REG_W-1:1], srq_o};
endmodule

// File: rtl/sts_irq_aggregator.sv
module sts_irq_aggregator
   import sts_pkg::*;
#(
   parameter int NUM_CH = 4,
   parameter int ADDR_W = 3
) (
   input  logic                    clk_i,
   input  logic                    rst_ni,
   input  logic                    soft_rst_i,
   input  logic [NUM_CH-1:0]       ch_rst_i,
   input  logic [REG_W-1:0]        glb_std_set_i,
   input  logic [REG_W-1:0]        glb_std_clr_i,
   input  logic [NUM_CH*REG_W-1:0] ch_std_set_i,
   input  logic [NUM_CH*REG_W-1:0] ch_std_clr_i,
   input  logic [NUM_CH*REG_W-1:0] ch_aux_set_i,
   input  logic [NUM_CH*REG_W-1:0] ch_aux_clr_i,
   input  logic [ADDR_W-1:0]       host_addr_i,
   input  logic [1:0]              host_sel_i,
   input  logic                    host_wr_i,
   input  logic [REG_W-1:0]        host_wdata_i,
   output logic [REG_W-1:0]        host_rdata_o,
   output logic                    irq_no
);
   localparam int N_ENT = NUM_CH + 1;

   if (NUM_CH < 1) begin : g_chk_ch
      $error("sts_irq_aggregator: NUM_CH must be at least 1");
   end
   if (N_ENT > (1 << ADDR_W)) begin : g_chk_addr
      $error("sts_irq_aggregator: ADDR_W too narrow for NUM_CH+1 entries");
   end

   logic [NUM_CH*REG_W-1:0] ch_std_flat;
   logic [NUM_CH*REG_W-1:0] ch_aux_flat;
   logic [N_ENT*REG_W-1:0]  smask_flat;
   logic [N_ENT*REG_W-1:0]  amask_flat;
   logic [N_ENT*REG_W-1:0]  std_view_flat;
   logic [N_ENT*REG_W-1:0]  aux_view_flat;
   logic [N_ENT-1:0]        srq_vec;
   logic [N_ENT-1:0]        ent_sel;
   logic [REG_W-1:0]        glb_std_q;
   logic [REG_W-1:0]        glb_aux_or;
   logic [REG_W-1:0]        glb_std_raw;
   logic                    srq_any;
   logic                    irq_q;
   logic                    wr_smsk;
   logic                    wr_amsk;

   assign wr_smsk = host_wr_i && (host_sel_i == SEL_SMSK);
   assign wr_amsk = host_wr_i && (host_sel_i == SEL_AMSK);

   for (genvar e = 0; e < N_ENT; e++) begin : g_sel
      assign ent_sel[e] = (host_addr_i == ADDR_W'(e));

      sts_mask_pair #(
         .STD_DEF(STD_MASK_DEF),
         .AUX_DEF(AUX_MASK_DEF)
      ) u_mask (
         .clk_i    (clk_i),
         .rst_ni   (rst_ni),
         .wr_std_i (wr_smsk && ent_sel[e]),
         .wr_aux_i (wr_amsk && ent_sel[e]),
         .wdata_i  (host_wdata_i),
         .std_o    (smask_flat[e*REG_W +: REG_W]),
         .aux_o    (amask_flat[e*REG_W +: REG_W])
      );
   end

   for (genvar k = 0; k < NUM_CH; k++) begin : g_ch
      logic             wipe;
      logic [REG_W-1:0] std_raw;
      logic [REG_W-1:0] aux_q;

      assign wipe = soft_rst_i | ch_rst_i[k];

      sts_entry_regs #(.STORE(CH_STD_STORE)) u_std (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .wipe_i (wipe),
         .set_i  (ch_std_set_i[k*REG_W +: REG_W]),
         .clr_i  (ch_std_clr_i[k*REG_W +: REG_W]),
         .q_o    (ch_std_flat[k*REG_W +: REG_W])
      );

      sts_entry_regs #(.STORE(AUX_STORE)) u_aux (
         .clk_i  (clk_i),
         .rst_ni (rst_ni),
         .wipe_i (wipe),
         .set_i  (ch_aux_set_i[k*REG_W +: REG_W]),
         .clr_i  (ch_aux_clr_i[k*REG_W +: REG_W]),
         .q_o    (ch_aux_flat[k*REG_W +: REG_W])
      );

      assign aux_q   = ch_aux_flat[k*REG_W +: REG_W];
      assign std_raw = ch_std_flat[k*REG_W +: REG_W] | ((|aux_q) ? AUXAV_BIT : '0);

      sts_srq_calc u_srq (
         .std_i   (std_raw),
         .aux_i   (aux_q),
         .smask_i (smask_flat[(k+1)*REG_W +: REG_W]),
         .amask_i (amask_flat[(k+1)*REG_W +: REG_W]),
         .srq_o   (srq_vec[k+1]),
         .view_o  (std_view_flat[(k+1)*REG_W +: REG_W])
      );

      assign aux_view_flat[(k+1)*REG_W +: REG_W] = aux_q;
   end

   sts_entry_regs #(.STORE(GLB_STD_STORE)) u_glb_std (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wipe_i (soft_rst_i),
      .set_i  (glb_std_set_i),
      .clr_i  (glb_std_clr_i),
      .q_o    (glb_std_q)
   );

   always_comb begin
      glb_aux_or = '0;
      for (int k = 0; k < NUM_CH; k++) begin
         glb_aux_or = glb_aux_or | ch_aux_flat[k*REG_W +: REG_W];
      end
   end

   assign glb_std_raw = glb_std_q | ((|glb_aux_or) ? AUXAV_BIT : '0);

   sts_srq_calc u_glb_srq (
      .std_i   (glb_std_raw),
      .aux_i   (glb_aux_or),
      .smask_i (smask_flat[0 +: REG_W]),
      .amask_i (amask_flat[0 +: REG_W]),
      .srq_o   (srq_vec[0]),
      .view_o  (std_view_flat[0 +: REG_W])
   );

   assign aux_view_flat[0 +: REG_W] = glb_aux_or;
   assign srq_any = |srq_vec;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) irq_q <= 1'b1;
      else         irq_q <= ~srq_any;
   end

   assign irq_no = irq_q;

   always_comb begin
      host_rdata_o = '0;
      for (int e = 0; e < N_ENT; e++) begin
         if (ent_sel[e]) begin
            case (host_sel_i)
               SEL_STD:  host_rdata_o = std_view_flat[e*REG_W +: REG_W];
               SEL_AUX:  host_rdata_o = aux_view_flat[e*REG_W +: REG_W];
               SEL_SMSK: host_rdata_o = smask_flat[e*REG_W +: REG_W];
               default:  host_rdata_o = amask_flat[e*REG_W +: REG_W];
            endcase
         end
      end
   end
endmodule

// File: rtl/sts_irq_aggregator_chk.sv
module sts_irq_aggregator_chk
   import sts_pkg::*;
#(
   parameter int NUM_CH = 4
) (
   input logic                      clk_i,
   input logic                      rst_ni,
   input logic                      soft_rst_i,
   input logic [NUM_CH-1:0]         ch_rst_i,
   input logic [NUM_CH*REG_W-1:0]   ch_std_set_i,
   input logic [NUM_CH*REG_W-1:0]   ch_std_flat_i,
   input logic [1:0]                host_sel_i,
   input logic                      host_wr_i,
   input logic [REG_W-1:0]          host_rdata_i,
   input logic [2*(NUM_CH+1)*REG_W-1:0] mask_flat_i,
   input logic                      srq_any_i,
   input logic                      irq_ni
);
   AST_IRQ_LATENCY: assert property (@(posedge clk_i) disable iff (!rst_ni)
      1'b1 |=> (irq_ni == !$past(srq_any_i))) else $error("irq latency"); // R8

   AST_STD_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_sel_i == SEL_STD) |-> (host_rdata_i[REG_W-1:9] == '0)) else $error("std reserved"); // R3

   AST_AUX_RSVD_ZERO: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (host_sel_i == SEL_AUX) |-> (host_rdata_i[REG_W-1:5] == '0)) else $error("aux reserved"); // R3

   AST_MASK_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !host_wr_i |=> $stable(mask_flat_i)) else $error("mask changed"); // R6

   for (genvar k = 0; k < NUM_CH; k++) begin : g_cap
      AST_SET_CAPTURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
         (ch_std_set_i[k*REG_W+1] && !soft_rst_i && !ch_rst_i[k])
            |=> ch_std_flat_i[k*REG_W+1]) else $error("set lost"); // R1
   end
endmodule

bind sts_irq_aggregator sts_irq_aggregator_chk #(.NUM_CH(NUM_CH)) u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .soft_rst_i    (soft_rst_i),
   .ch_rst_i      (ch_rst_i),
   .ch_std_set_i  (ch_std_set_i),
   .ch_std_flat_i (ch_std_flat),
   .host_sel_i    (host_sel_i),
   .host_wr_i     (host_wr_i),
   .host_rdata_i  (host_rdata_o),
   .mask_flat_i   ({smask_flat, amask_flat}),
   .srq_any_i     (srq_any),
   .irq_ni        (irq_no)
);

// File: tb/sts_irq_aggregator_tb_top.sv
module sts_irq_aggregator_tb_top;
   localparam int NCH = 4;
   localparam int AW  = 3;
   localparam int W   = 16;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             soft_rst = 1'b0;
   logic [NCH-1:0]   ch_rst = '0;
   logic [W-1:0]     g_set = '0, g_clr = '0;
   logic [NCH*W-1:0] s_set = '0, s_clr = '0, a_set = '0, a_clr = '0;
   logic [AW-1:0]    haddr = '0;
   logic [1:0]       hsel = '0;
   logic             hwr = 1'b0;
   logic [W-1:0]     hwdata = '0;
   logic [W-1:0]     hrdata;
   logic             irq_n;

   int total = 0;
   int bad = 0;

   always #10 clk = ~clk;

   sts_irq_aggregator #(.NUM_CH(NCH), .ADDR_W(AW)) dut_i (
      .clk_i(clk), .rst_ni(rst_n), .soft_rst_i(soft_rst), .ch_rst_i(ch_rst),
      .glb_std_set_i(g_set), .glb_std_clr_i(g_clr),
      .ch_std_set_i(s_set), .ch_std_clr_i(s_clr),
      .ch_aux_set_i(a_set), .ch_aux_clr_i(a_clr),
      .host_addr_i(haddr), .host_sel_i(hsel), .host_wr_i(hwr),
      .host_wdata_i(hwdata), .host_rdata_o(hrdata), .irq_no(irq_n)
   );

   typedef struct packed {
      logic [1:0]  ch;
      logic [15:0] sset;
      logic [15:0] aset;
      logic [15:0] est;
      logic [15:0] eau;
      logic [15:0] egst;
      logic [15:0] egau;
      logic        eirq;
   } vec_t;

   localparam vec_t VECS [6] = '{
      '{2'd0, 16'h0002, 16'h0000, 16'h0003, 16'h0000, 16'h0000, 16'h0000, 1'b0},
      '{2'd1, 16'h0100, 16'h0004, 16'h0111, 16'h0004, 16'h0011, 16'h0004, 1'b0},
      '{2'd2, 16'h0000, 16'h0010, 16'h0011, 16'h0010, 16'h0011, 16'h0010, 1'b0},
      '{2'd3, 16'hFE19, 16'hFFE0, 16'h0000, 16'h0000, 16'h0000, 16'h0000, 1'b1},
      '{2'd0, 16'h0106, 16'h001F, 16'h0117, 16'h001F, 16'h0011, 16'h001F, 1'b0},
      '{2'd2, 16'h0004, 16'h0000, 16'h0005, 16'h0000, 16'h0000, 16'h0000, 1'b0}
   };

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic rd(input int addr, input int sel, output logic [W-1:0] v);
      haddr = AW'(addr);
      hsel  = 2'(sel);
      #2;
      v = hrdata;
   endtask

   task automatic check_rd(input string tag, input int addr, input int sel, input logic [W-1:0] exp);
      logic [W-1:0] v;
      rd(addr, sel, v);
      check(tag, v, exp);
   endtask

   task automatic check_irq(input string tag, input logic exp);
      check(tag, {15'd0, irq_n}, {15'd0, exp});
   endtask

   task automatic tick();
      @(negedge clk);
   endtask

   task automatic wr_mask(input int addr, input int sel, input logic [W-1:0] d);
      tick();
      haddr = AW'(addr); hsel = 2'(sel); hwdata = d; hwr = 1'b1;
      tick();
      hwr = 1'b0;
   endtask

   task automatic pulse_soft();
      tick(); soft_rst = 1'b1;
      tick(); soft_rst = 1'b0;
   endtask

   task automatic strobe_ch(input int ch, input logic [W-1:0] ss, input logic [W-1:0] sc,
                            input logic [W-1:0] as, input logic [W-1:0] ac);
      tick();
      s_set[ch*W +: W] = ss; s_clr[ch*W +: W] = sc;
      a_set[ch*W +: W] = as; a_clr[ch*W +: W] = ac;
      tick();
      s_set = '0; s_clr = '0; a_set = '0; a_clr = '0;
   endtask

   initial begin
      #(20 * 100000);
      bad++; total++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (3) tick();
      rst_n = 1'b1;
      tick();

      // reset state: R6 mask defaults, status zero, R8 line high
      check_irq("R8 reset irq high", 1'b1);
      for (int e = 0; e <= NCH; e++) begin
         check_rd("R6 reset std mask", e, 2, 16'hFFFF);
         check_rd("R6 reset aux mask", e, 3, 16'h0000);
         check_rd("R10 reset std status", e, 0, 16'h0000);
      end

      // table walk: R3 R4 R5 R7 R8
      foreach (VECS[i]) begin
         pulse_soft();
         strobe_ch(int'(VECS[i].ch), VECS[i].sset, 16'h0000, VECS[i].aset, 16'h0000);
         check_rd("R4 R7 vec ch std", int'(VECS[i].ch) + 1, 0, VECS[i].est);
         check_rd("R3 R4 vec ch aux", int'(VECS[i].ch) + 1, 1, VECS[i].eau);
         check_rd("R5 vec glb std", 0, 0, VECS[i].egst);
         check_rd("R5 vec glb aux", 0, 1, VECS[i].egau);
         tick();
         check_irq("R8 vec irq", VECS[i].eirq);
      end

      // R1 set beats clear; R2 clear removes
      pulse_soft();
      strobe_ch(1, 16'h0002, 16'h0002, 16'h0000, 16'h0000);
      check_rd("R1 set wins over clear", 2, 0, 16'h0003);
      strobe_ch(1, 16'h0000, 16'h0002, 16'h0000, 16'h0000);
      check_rd("R2 clear on condition gone", 2, 0, 16'h0000);

      // R7 mask gating, mask bit 0 ignored; R8 latency
      wr_mask(1, 2, 16'h0000);
      strobe_ch(0, 16'h0004, 16'h0000, 16'h0000, 16'h0000);
      check_rd("R7 masked std no srq", 1, 0, 16'h0004);
      tick();
      check_irq("R8 masked irq high", 1'b1);
      wr_mask(1, 2, 16'h0001);
      check_rd("R7 mask bit0 ignored", 1, 0, 16'h0004);
      tick();
      check_irq("R7 mask bit0 irq high", 1'b1);
      wr_mask(1, 2, 16'h0004);
      check_rd("R7 unmasked srq", 1, 0, 16'h0005);
      check_irq("R8 irq one cycle late", 1'b1);
      tick();
      check_irq("R8 irq asserted", 1'b0);

      // R7 auxiliary mask path
      pulse_soft();
      wr_mask(2, 2, 16'h0000);
      wr_mask(0, 2, 16'h0000);
      strobe_ch(1, 16'h0000, 16'h0000, 16'h0001, 16'h0000);
      check_rd("R4 aux avail no srq", 2, 0, 16'h0010);
      tick();
      check_irq("R7 aux masked irq high", 1'b1);
      wr_mask(2, 3, 16'h0001);
      check_rd("R7 aux mask srq", 2, 0, 16'h0011);
      tick();
      check_irq("R8 aux srq irq low", 1'b0);

      // R6 R10 masks survive reset commands
      pulse_soft();
      check_rd("R10 soft clears aux", 2, 1, 16'h0000);
      check_rd("R6 aux mask kept", 2, 3, 16'h0001);
      check_rd("R6 std mask kept", 1, 2, 16'h0004);
      check_rd("R6 glb mask kept", 0, 2, 16'h0000);
      strobe_ch(2, 16'h0100, 16'h0000, 16'h0000, 16'h0000);
      strobe_ch(3, 16'h0100, 16'h0000, 16'h0000, 16'h0000);
      check_rd("R1 ch2 operational", 3, 0, 16'h0101);
      tick(); ch_rst = 4'b0100;
      tick(); ch_rst = '0;
      check_rd("R10 ch reset clears own", 3, 0, 16'h0000);
      check_rd("R10 ch reset spares other", 4, 0, 16'h0101);
      check_rd("R6 ch reset keeps mask", 3, 2, 16'hFFFF);

      // R1 global invalid command, R3 ignored global bits
      pulse_soft();
      tick(); g_set = 16'hFE19;
      tick(); g_set = '0;
      check_rd("R1 R3 glb bit3 only", 0, 0, 16'h0008);
      tick();
      check_irq("R7 glb masked irq high", 1'b1);
      wr_mask(0, 2, 16'h0008);
      check_rd("R7 glb srq", 0, 0, 16'h0009);
      tick();
      check_irq("R8 glb irq low", 1'b0);

      // R9 unused addresses
      check_rd("R9 unused addr reads 0", 5, 2, 16'h0000);
      for (int a = NCH + 1; a < 8; a++) wr_mask(a, 2, 16'h1234);
      check_rd("R9 no alias ch0", 1, 2, 16'h0004);
      check_rd("R9 no alias ch1", 2, 2, 16'h0000);
      check_rd("R9 no alias ch2", 3, 2, 16'hFFFF);
      check_rd("R9 no alias ch3", 4, 2, 16'hFFFF);

      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule